// File: doc/BRIEF.md
# Vector Floating-Point Classify Unit

This unit sorts every element of a packed vector of IEEE-754 values into one of ten categories and produces a one-hot class code for each. The category depends on the sign, on infinity, zero, subnormal or normal magnitude, and on whether a NaN is signaling or quiet. The element width is chosen per operation (16, 32 or 64 bits). The 10-bit code is zero-extended into a destination element of the same width, at the same position as its source element.

An operation begins with a one-cycle start strobe. The unit captures the source vector, the v0 mask bits, the mask-enable flag, the vector length and the width select. It then walks the elements one per clock. Elements below the vector length are classified unless masking suppresses them. Elements from the vector length up to the maximum element count for the chosen width are written as zero. A per-element write-enable tells the register file which destination elements to update. A masked-off element gets no write-enable, so the register file keeps its old contents. A single-cycle done pulse marks the end of the operation.

Top module: `vfclass_unit`

## Requirements
- R1: For a non-NaN element the code sets exactly one bit: bit 0 for negative infinity, bit 1 for negative normal, bit 2 for negative subnormal, bit 3 for negative zero, bit 4 for positive zero, bit 5 for positive subnormal, bit 6 for positive normal and bit 7 for positive infinity.
- R2: An all-ones exponent with a nonzero fraction is a NaN. It sets bit 9 when the top fraction bit is 1 (quiet) and bit 8 when that bit is 0 (signaling), whatever the sign.
- R3: The tests run in priority order: infinity, zero, subnormal, NaN, normal. Each written element holds only its 10-bit code, with all upper bits of the element zero.
- R4: ew_sel 0 selects 16-bit elements, 1 selects 32-bit elements, and 2 or 3 selects 64-bit elements. The maximum element count is VLEN divided by the element width. Element i occupies dst_vec/src_vec bits [i*EW +: EW] and elem_we bit i.
- R5: With mask_en=1, an element below vl whose v0_mask bit is 0 gets elem_we 0 and a zero field in dst_vec. With mask_en=0, v0_mask has no effect.
- R6: Elements from vl up to the maximum count minus one get elem_we 1 and a zero field. A vl larger than the maximum count is treated as the maximum count.
- R7: One element is handled per clock. done is high for exactly one cycle, in the cycle after the Nth rising edge that follows the start edge, where N is the maximum element count.
- R8: With vl=0, no element is classified, every element is written as zero, and done still arrives after N edges.
- R9: A start accepted while idle clears dst_vec and elem_we. A start during an operation is ignored. Outputs hold their values while the unit is idle.
- R10: After reset, dst_vec, elem_we and done are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| ew_sel | input | 2 | Element width select |
| mask_en | input | 1 | Apply v0_mask to active elements |
| vl | input | VL_W (4) | Number of active elements |
| v0_mask | input | MAXE (8) | Mask bit per element index |
| src_vec | input | VLEN (128) | Packed source elements |
| dst_vec | output | VLEN (128) | Packed class codes |
| elem_we | output | MAXE (8) | Write-enable per element index |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start strobe that lands in the middle of a running operation. It must change neither the element count, the codes nor the timing of done. The bench raises start again a few cycles into a 16-bit run, with different width, length and data, and checks that the result and the cycle count both match the first request. It also combines masking with a length below the maximum. This puts masked-off elements, classified elements and tail zeroes side by side in one destination, so each element's write-enable is checked against its own rule.

// File: rtl/vfclass_pkg.sv
package vfclass_pkg;

    typedef enum logic [1:0] {
        EW_H     = 2'b00,
        EW_W     = 2'b01,
        EW_D     = 2'b10,
        EW_D_ALT = 2'b11
    } ew_e;

    localparam int CODE_W = 10;

    localparam int CB_NEG_INF  = 0;
    localparam int CB_NEG_NORM = 1;
    localparam int CB_NEG_SUB  = 2;
    localparam int CB_NEG_ZERO = 3;
    localparam int CB_POS_ZERO = 4;
    localparam int CB_POS_SUB  = 5;
    localparam int CB_POS_NORM = 6;
    localparam int CB_POS_INF  = 7;
    localparam int CB_SNAN     = 8;
    localparam int CB_QNAN     = 9;

endpackage

// File: rtl/vfclass_decode.sv
module vfclass_decode
    import vfclass_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output logic [CODE_W-1:0]     code
);

    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    assign sgn       = operand[EXP_W+FRAC_W];
    assign expo      = operand[EXP_W+FRAC_W-1:FRAC_W];
    assign frac      = operand[FRAC_W-1:0];
    assign exp_ones  = &expo;
    assign exp_zero  = ~|expo;
    assign frac_zero = ~|frac;

    always_comb begin
        code = '0;
        if (exp_ones && frac_zero) begin
            code[sgn ? CB_NEG_INF : CB_POS_INF] = 1'b1;
        end else if (exp_zero && frac_zero) begin
            code[sgn ? CB_NEG_ZERO : CB_POS_ZERO] = 1'b1;
        end else if (exp_zero) begin
            code[sgn ? CB_NEG_SUB : CB_POS_SUB] = 1'b1;
        end else if (exp_ones) begin
            code[frac[FRAC_W-1] ? CB_QNAN : CB_SNAN] = 1'b1;
        end else begin
            code[sgn ? CB_NEG_NORM : CB_POS_NORM] = 1'b1;
        end
    end

endmodule

// File: rtl/vfclass_elem_pick.sv
module vfclass_elem_pick
    import vfclass_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int IDX_W = 3
) (
    input  logic [VLEN-1:0]  src,
    input  logic [IDX_W-1:0] idx,
    input  ew_e              ew,
    output logic [63:0]      elem
);

    always_comb begin
        case (ew)
            EW_H:    elem = {48'd0, src[{idx, 4'b0000} +: 16]};
            EW_W:    elem = {32'd0, src[{idx, 5'b00000} +: 32]};
            default: elem = src[{idx, 6'b000000} +: 64];
        endcase
    end

endmodule

// File: rtl/vfclass_unit.sv
module vfclass_unit
    import vfclass_pkg::*;
#(
    parameter  int VLEN  = 128,
    localparam int MAXE  = VLEN / 16,
    localparam int VL_W  = $clog2(MAXE) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      ew_sel,
    input  logic            mask_en,
    input  logic [VL_W-1:0] vl,
    input  logic [MAXE-1:0] v0_mask,
    input  logic [VLEN-1:0] src_vec,
    output logic [VLEN-1:0] dst_vec,
    output logic [MAXE-1:0] elem_we,
    output logic            done
);

    localparam int IDX_W = $clog2(MAXE);
    localparam int OFF_W = IDX_W + 6;
    localparam int NFMT  = 3;
    localparam int EXPS  [NFMT] = '{5, 8, 11};
    localparam int FRACS [NFMT] = '{10, 23, 52};

    typedef struct packed {
        logic            busy;
        logic            done;
        ew_e             ew;
        logic            msk_en;
        logic [VL_W-1:0] vl_eff;
        logic [VL_W-1:0] vlmax;
        logic [VL_W-1:0] idx;
        logic [MAXE-1:0] v0;
        logic [VLEN-1:0] src;
        logic [VLEN-1:0] dst;
        logic [MAXE-1:0] we;
    } state_t;

    state_t st_d, st_q;

    logic [63:0]        elem;
    logic [CODE_W-1:0]  codes [NFMT];
    logic [CODE_W-1:0]  code_sel;
    logic [VLEN-1:0]    code_vec;
    logic [OFF_W-1:0]   off;
    logic [VL_W-1:0]    vlmax_in;
    ew_e                ew_in;
    logic               busy_w;

    vfclass_elem_pick #(
        .VLEN  (VLEN),
        .IDX_W (IDX_W)
    ) u_pick (
        .src  (st_q.src),
        .idx  (st_q.idx[IDX_W-1:0]),
        .ew   (st_q.ew),
        .elem (elem)
    );

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        vfclass_decode #(
            .EXP_W  (EXPS[g]),
            .FRAC_W (FRACS[g])
        ) u_dec (
            .operand (elem[EXPS[g]+FRACS[g]:0]),
            .code    (codes[g])
        );
    end

    assign ew_in = ew_e'(ew_sel);

    always_comb begin
        case (ew_in)
            EW_H:    vlmax_in = VL_W'(MAXE);
            EW_W:    vlmax_in = VL_W'(MAXE / 2);
            default: vlmax_in = VL_W'(MAXE / 4);
        endcase
    end

    always_comb begin
        case (st_q.ew)
            EW_H: begin
                code_sel = codes[0];
                off      = OFF_W'({st_q.idx[IDX_W-1:0], 4'b0000});
            end
            EW_W: begin
                code_sel = codes[1];
                off      = OFF_W'({st_q.idx[IDX_W-1:0], 5'b00000});
            end
            default: begin
                code_sel = codes[2];
                off      = OFF_W'({st_q.idx[IDX_W-1:0], 6'b000000});
            end
        endcase
        code_vec = {{(VLEN-CODE_W){1'b0}}, code_sel} << off;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.ew     = ew_in;
                st_d.msk_en = mask_en;
                st_d.vl_eff = (vl > vlmax_in) ? vlmax_in : vl;
                st_d.vlmax  = vlmax_in;
                st_d.idx    = '0;
                st_d.v0     = v0_mask;
                st_d.src    = src_vec;
                st_d.dst    = '0;
                st_d.we     = '0;
            end
        end else begin
            if (st_q.idx >= st_q.vl_eff) begin
                st_d.we[st_q.idx[IDX_W-1:0]] = 1'b1;
            end else if (!st_q.msk_en || st_q.v0[st_q.idx[IDX_W-1:0]]) begin
                st_d.we[st_q.idx[IDX_W-1:0]] = 1'b1;
                st_d.dst = st_q.dst | code_vec;
            end
            if (st_q.idx == st_q.vlmax - 1'b1) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_vec = st_q.dst;
    assign elem_we = st_q.we;
    assign done    = st_q.done;
    assign busy_w  = st_q.busy;

endmodule

// File: rtl/vfclass_unit_chk.sv
module vfclass_unit_chk #(
    parameter int VLEN = 128,
    parameter int MAXE = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [MAXE-1:0] elem_we,
    input logic [VLEN-1:0] dst_vec
);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && elem_we == '0 && dst_vec == '0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(dst_vec) && $stable(elem_we))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7

    AST_ONE_ELEM_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(elem_we) <= $countones($past(elem_we)) + 1)); // R7

    AST_WE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (($past(elem_we) & ~elem_we) == '0)); // R6

    AST_ONE_BIT_PER_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dst_vec) <= $countones(elem_we)); // R3

endmodule

bind vfclass_unit vfclass_unit_chk #(
    .VLEN (VLEN),
    .MAXE (MAXE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy_w),
    .done    (done),
    .elem_we (elem_we),
    .dst_vec (dst_vec)
);

// File: tb/tb_vfclass_unit.sv
`timescale 1ns/1ps
module tb_vfclass_unit;

    localparam int VLEN = 128;
    localparam int MAXE = 8;
    localparam int NTBL = 23;

    // entry: {ew_sel[1:0], value[63:0], expected code[9:0]}
    localparam logic [75:0] TBL [NTBL] = '{
        {2'd0, 64'h7C00, 10'h080},               // R1 +inf
        {2'd0, 64'hFC00, 10'h001},               // R1 -inf
        {2'd0, 64'h0000, 10'h010},               // R1 +0
        {2'd0, 64'h8000, 10'h008},               // R1 -0
        {2'd0, 64'h0001, 10'h020},               // R1 +sub
        {2'd0, 64'h83FF, 10'h004},               // R1 -sub
        {2'd0, 64'h3C00, 10'h040},               // R1 +norm
        {2'd0, 64'hC000, 10'h002},               // R1 -norm
        {2'd0, 64'h7E00, 10'h200},               // R2 qNaN
        {2'd0, 64'h7C01, 10'h100},               // R2 sNaN
        {2'd0, 64'hFD00, 10'h100},               // R2 negative sNaN
        {2'd1, 64'h7F800000, 10'h080},           // R1 +inf
        {2'd1, 64'hFFC00000, 10'h200},           // R2 negative qNaN
        {2'd1, 64'h807FFFFF, 10'h004},           // R1 -sub
        {2'd1, 64'h00800000, 10'h040},           // R3 smallest normal
        {2'd1, 64'h7F800001, 10'h100},           // R2 sNaN
        {2'd2, 64'hFFF0000000000000, 10'h001},   // R1 -inf
        {2'd2, 64'h8000000000000000, 10'h008},   // R1 -0
        {2'd2, 64'h7FF8000000000000, 10'h200},   // R2 qNaN
        {2'd2, 64'h000FFFFFFFFFFFFF, 10'h020},   // R3 largest subnormal
        {2'd2, 64'h7FEFFFFFFFFFFFFF, 10'h040},   // R1 largest normal
        {2'd2, 64'h7FF0000000000001, 10'h100},   // R2 sNaN
        {2'd3, 64'hBFF0000000000000, 10'h002}    // R4 alt 64-bit code
    };

    logic            clk;
    logic            rst_n;
    logic            start;
    logic [1:0]      ew_sel;
    logic            mask_en;
    logic [3:0]      vl;
    logic [MAXE-1:0] v0_mask;
    logic [VLEN-1:0] src_vec;
    logic [VLEN-1:0] dst_vec;
    logic [MAXE-1:0] elem_we;
    logic            done;

    int n_checks;
    int n_fails;
    bit finished;

    vfclass_unit #(.VLEN(VLEN)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ew_sel  (ew_sel),
        .mask_en (mask_en),
        .vl      (vl),
        .v0_mask (v0_mask),
        .src_vec (src_vec),
        .dst_vec (dst_vec),
        .elem_we (elem_we),
        .done    (done)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic int ew_bits(input logic [1:0] e);
        return (e == 2'd0) ? 16 : (e == 2'd1) ? 32 : 64;
    endfunction

    function automatic int max_elems(input logic [1:0] e);
        return VLEN / ew_bits(e);
    endfunction

    function automatic logic [9:0] ref_class(input logic [1:0] e, input logic [63:0] v);
        int eb, fb;
        logic s, all1, all0, fz, qb;
        eb = (e == 2'd0) ? 5 : (e == 2'd1) ? 8 : 11;
        fb = (e == 2'd0) ? 10 : (e == 2'd1) ? 23 : 52;
        s = v[eb + fb];
        all1 = 1'b1; all0 = 1'b1; fz = 1'b1;
        for (int k = 0; k < eb; k++) begin
            if (v[fb + k]) all0 = 1'b0; else all1 = 1'b0;
        end
        for (int k = 0; k < fb; k++) if (v[k]) fz = 1'b0;
        qb = v[fb - 1];
        if (all1 && fz)      return s ? 10'h001 : 10'h080;
        else if (all0 && fz) return s ? 10'h008 : 10'h010;
        else if (all0)       return s ? 10'h004 : 10'h020;
        else if (all1)       return qb ? 10'h200 : 10'h100;
        else                 return s ? 10'h002 : 10'h040;
    endfunction

    task automatic calc(input logic [1:0] e, input logic men, input int vlv,
                        input logic [VLEN-1:0] s, input logic [MAXE-1:0] m,
                        output logic [VLEN-1:0] xd, output logic [MAXE-1:0] xw);
        int w, n, ve;
        logic [63:0] el;
        w = ew_bits(e); n = max_elems(e);
        ve = (vlv > n) ? n : vlv;
        xd = '0; xw = '0;
        for (int i = 0; i < n; i++) begin
            el = '0;
            for (int b = 0; b < w; b++) el[b] = s[i * w + b];
            if (i >= ve) begin
                xw[i] = 1'b1;
            end else if (!men || m[i]) begin
                xw[i] = 1'b1;
                for (int b = 0; b < 10; b++) xd[i * w + b] = ref_class(e, el)[b];
            end
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] e, input logic men, input logic [3:0] vlv,
                          input logic [VLEN-1:0] s, input logic [MAXE-1:0] m,
                          output int cyc);
        @(negedge clk);
        ew_sel = e; mask_en = men; vl = vlv; src_vec = s; v0_mask = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic full_op(input string req, input logic [1:0] e, input logic men,
                           input logic [3:0] vlv, input logic [VLEN-1:0] s,
                           input logic [MAXE-1:0] m);
        int cyc;
        logic [VLEN-1:0] xd;
        logic [MAXE-1:0] xw;
        calc(e, men, int'(vlv), s, m, xd, xw);
        run_op(e, men, vlv, s, m, cyc);
        check(req, "dst_vec", dst_vec, xd);
        check(req, "elem_we", VLEN'(elem_we), VLEN'(xw));
        check("R7", "cycles to done", VLEN'(cyc), VLEN'(max_elems(e)));
        @(negedge clk);
        check("R7", "done width", VLEN'(done), '0);
    endtask

    initial begin
        n_checks = 0; n_fails = 0; finished = 0;
        rst_n = 1'b0; start = 1'b0; ew_sel = '0; mask_en = 1'b0; vl = '0;
        v0_mask = '0; src_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset dst", dst_vec, '0);
        check("R10", "reset we", VLEN'(elem_we), '0);
        check("R10", "reset done", VLEN'(done), '0);
        rst_n = 1'b1;

        // table walk: element 0 classified, the rest is tail (R1 R2 R3 R4 R6)
        for (int t = 0; t < NTBL; t++) begin
            logic [1:0]  e;
            logic [63:0] v;
            logic [9:0]  xc;
            logic [VLEN-1:0] s, xd;
            int cyc;
            e = TBL[t][75:74]; v = TBL[t][73:10]; xc = TBL[t][9:0];
            s = {VLEN{1'b1}};
            for (int b = 0; b < ew_bits(e); b++) s[b] = v[b];
            run_op(e, 1'b0, 4'd1, s, '0, cyc);
            xd = VLEN'(xc);
            check("R1", "table class code", dst_vec, xd);
            check("R6", "table we", VLEN'(elem_we), VLEN'((1 << max_elems(e)) - 1));
            check("R7", "table cycles", VLEN'(cyc), VLEN'(max_elems(e)));
        end

        // R4 R1 R2: eight mixed 16-bit elements
        full_op("R4", 2'd0, 1'b0, 4'd8,
                {16'h7C01, 16'h7E00, 16'h3C00, 16'h0001, 16'h8000, 16'h0000, 16'hFC00, 16'h7C00}, '0);
        // R5: masking on 32-bit elements, elements 1 and 3 off
        full_op("R5", 2'd1, 1'b1, 4'd4,
                {32'h7FC00000, 32'h00000001, 32'hFF800000, 32'h3F800000}, 8'b1111_0101);
        // R5: mask_en=0 ignores an all-zero v0
        full_op("R5", 2'd1, 1'b0, 4'd4,
                {32'h7FC00000, 32'h00000001, 32'hFF800000, 32'h3F800000}, 8'h00);
        // R6: tail after vl=3, nonzero source in the tail, mask mixed in
        full_op("R6", 2'd0, 1'b1, 4'd3, {VLEN{1'b1}} ^ 128'h0000_0000_0000_0000_0000_8000_7C00_3C00 ^ {VLEN{1'b1}} | {80'hFFFF_FFFF_FFFF_FFFF_FFFF, 48'h0}, 8'b0000_0101);
        // R8: vl=0 on 64-bit elements
        full_op("R8", 2'd2, 1'b0, 4'd0, {64'h3FF0000000000000, 64'h7FF0000000000000}, '0);
        // R6: vl beyond the maximum count is clamped
        full_op("R6", 2'd2, 1'b0, 4'd15, {64'h3FF0000000000000, 64'h7FF0000000000000}, '0);
        // R4: ew_sel=3 acts as 64-bit
        full_op("R4", 2'd3, 1'b0, 4'd2, {64'h8000000000000001, 64'h7FF4000000000000}, '0);

        // R9: start during a run is ignored
        begin
            logic [VLEN-1:0] s1, xd;
            logic [MAXE-1:0] xw;
            int cyc;
            s1 = {16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h0200, 16'h8200, 16'h7D00, 16'h4000};
            calc(2'd0, 1'b0, 7, s1, '0, xd, xw);
            @(negedge clk);
            ew_sel = 2'd0; mask_en = 1'b0; vl = 4'd7; src_vec = s1; v0_mask = '0; start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            cyc = 0;
            repeat (2) begin @(posedge clk); @(negedge clk); cyc++; end
            ew_sel = 2'd2; vl = 4'd1; src_vec = '0; mask_en = 1'b1; start = 1'b1;
            @(posedge clk); @(negedge clk); cyc++;
            start = 1'b0;
            while (!done && cyc < 40) begin @(posedge clk); @(negedge clk); cyc++; end
            check("R9", "dst after mid-run start", dst_vec, xd);
            check("R9", "we after mid-run start", VLEN'(elem_we), VLEN'(xw));
            check("R9", "cycles after mid-run start", VLEN'(cyc), VLEN'(8));
            // R9: outputs hold while idle even with inputs changing
            src_vec = {VLEN{1'b1}}; vl = 4'd3;
            repeat (4) @(negedge clk);
            check("R9", "idle hold dst", dst_vec, xd);
            check("R9", "idle hold we", VLEN'(elem_we), VLEN'(xw));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R7 watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule